// File: doc/BRIEF.md
# Configuration DMA Command Front End

This block takes DMA commands from a register write port and turns them into a stream of 32-bit words for a device configuration port. Software stages a command in four registers: source address, destination address, source length and destination length. The write to the destination-length register commits the staged command into a small command queue. The queue depth is a parameter and defaults to four.

A fetch engine takes one command at a time from the queue. It reads words from a synchronous memory read port and presents each word on a valid/ready output stream. When the command is done it signals completion. The low bits of the source address carry flags, and the lengths count 32-bit words. A destination of all ones means "no destination", and that choice is carried to the stream as a sink selector. The queue reports full and empty status. A commit made while the queue is full is dropped, and the drop is signalled.

Top module: `cfg_dma_front`

## Requirements
- R1: A register write at byte offset 0x18 stages the source address, at 0x1C the destination address and at 0x20 the source length. A write at 0x24 (destination length) commits the staged command to the queue. Other offsets have no effect.
- R2: Lengths count 32-bit words. Only bits [26:0] of the source-length value are used, so the largest length is 0x7ffffff and the upper bits are ignored.
- R3: The first memory read address is the source address with bits [1:0] forced to zero. Each later read of the same command is 4 higher.
- R4: `cfg_valid` and `cfg_data` stay stable while `cfg_ready` is low. No memory read is issued while a word is waiting on the stream.
- R5: A command of length 0 issues no memory read and still raises `evt_dma_done` once.
- R6: If bit 0 of the source address is set, completion waits until `cfg_port_idle` is high. At that point `evt_port_done` and `evt_dma_done` pulse together in the same cycle. If bit 0 is clear, only `evt_dma_done` pulses and no `evt_port_done` is raised.
- R7: `cfg_writeback` is 0 for the words of a command whose destination address is 0xffffffff, and 1 otherwise.
- R8: The queue holds up to `CMDQ_DEPTH` (4) committed commands and executes them in commit order. `q_full` is high exactly when it holds that many, and `q_empty` is high exactly when it holds none.
- R9: A commit while `q_full` is high pulses `evt_q_overflow` for one cycle, and that command is never executed.
- R10: Writes to the source, destination or length staging registers do not alter commands already in the queue.
- R11: After reset, `q_empty` is 1, `q_full` is 0, `cfg_valid` and `mem_rd_en` are 0, and no event is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| q_full | output | 1 | Command queue full |
| q_empty | output | 1 | Command queue empty |
| evt_dma_done | output | 1 | One-cycle pulse: command complete |
| evt_port_done | output | 1 | One-cycle pulse: configuration port finished consuming the data |
| evt_q_overflow | output | 1 | One-cycle pulse: commit dropped because the queue was full |
| mem_rd_en | output | 1 | Memory read request; data is returned in the next cycle |
| mem_rd_addr | output | 32 | Memory read byte address, word aligned |
| mem_rd_data | input | 32 | Memory read data, valid one cycle after the request |
| cfg_valid | output | 1 | Stream word valid |
| cfg_data | output | 32 | Stream word |
| cfg_writeback | output | 1 | Sink selector: 0 when the command has no destination |
| cfg_ready | input | 1 | Stream consumer ready |
| cfg_port_idle | input | 1 | Configuration port has drained its input |

## Verification
The hardest state to reach from the ports is a full queue followed by an overflow. The engine pops the first command at once, so the queue only fills while the engine is blocked. The stimulus holds `cfg_ready` low so that the first command stays stuck on the stream. It then commits four more commands and a fifth, and rewrites the staging registers without committing. After that it releases the stream and checks that exactly the first five commands come out, in commit order. Port-wait completion is reached the same way: `cfg_port_idle` is held low after the last word is consumed.

// File: rtl/dmafe_pkg.sv
package dmafe_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 27;
  localparam int REG_AW = 8;

  localparam logic [REG_AW-1:0] OFS_SRC  = 8'h18;
  localparam logic [REG_AW-1:0] OFS_DST  = 8'h1C;
  localparam logic [REG_AW-1:0] OFS_SLEN = 8'h20;
  localparam logic [REG_AW-1:0] OFS_DLEN = 8'h24;

  localparam logic [ADDR_W-1:0] NO_DEST = '1;

  typedef struct packed {
    logic [ADDR_W-1:0] src;
    logic [ADDR_W-1:0] dst;
    logic [LEN_W-1:0]  words;
  } dma_cmd_t;

  typedef enum logic [2:0] {
    S_IDLE, S_LOAD, S_READ, S_CAPT, S_SEND, S_FINISH, S_PWAIT
  } fetch_state_t;
endpackage

// File: rtl/dmafe_stage.sv
module dmafe_stage
  import dmafe_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [REG_AW-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              full,
  output logic              push,
  output dma_cmd_t          cmd,
  output logic              ovf
);
  logic [ADDR_W-1:0] src_q, dst_q;
  logic [LEN_W-1:0]  len_q;
  logic              commit;

  assign commit = we && (addr == OFS_DLEN);
  assign push   = commit && !full;
  assign cmd    = '{src: src_q, dst: dst_q, words: len_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q <= '0;
      dst_q <= '0;
      len_q <= '0;
      ovf   <= 1'b0;
    end else begin
      ovf <= commit && full;
      if (we) begin
        case (addr)
          OFS_SRC:  src_q <= wdata;
          OFS_DST:  dst_q <= wdata;
          OFS_SLEN: len_q <= wdata[LEN_W-1:0];
          default:  ;
        endcase
      end
    end
  end

  // R9: an overflow pulse only follows a commit attempted while full
  a_r9_ovf_cause: assert property (@(posedge clk) disable iff (rst)
    ovf |-> $past(we && full));
endmodule

// File: rtl/dmafe_cmdq.sv
module dmafe_cmdq #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic             full,
  output logic             empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;

  assign full  = (count == FULL_CNT);
  assign empty = (count == '0);

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
    if (pop)  rdata <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: ;
      endcase
    end
  end

  // R8: the queue is never written when full nor read when empty
  a_r8_no_push_full: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
  a_r8_no_pop_empty: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
  a_r8_count_step: assert property (@(posedge clk) disable iff (rst)
    (push && !pop) |=> !empty);
endmodule

// File: rtl/dmafe_fetch.sv
module dmafe_fetch
  import dmafe_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              q_empty,
  input  dma_cmd_t          q_cmd,
  output logic              q_pop,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              str_valid,
  output logic [DATA_W-1:0] str_data,
  output logic              str_wb,
  input  logic              str_ready,
  input  logic              port_idle,
  output logic              evt_done,
  output logic              evt_port
);
  fetch_state_t      state;
  logic [ADDR_W-1:0] addr_q, first_addr;
  logic [LEN_W-1:0]  left_q;
  logic              wait_q, wb_q;

  assign q_pop      = (state == S_IDLE) && !q_empty;
  assign first_addr = {q_cmd.src[ADDR_W-1:2], 2'b00};

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      addr_q      <= '0;
      left_q      <= '0;
      wait_q      <= 1'b0;
      wb_q        <= 1'b0;
      mem_rd_en   <= 1'b0;
      mem_rd_addr <= '0;
      str_valid   <= 1'b0;
      str_data    <= '0;
      str_wb      <= 1'b0;
      evt_done    <= 1'b0;
      evt_port    <= 1'b0;
    end else begin
      evt_done <= 1'b0;
      evt_port <= 1'b0;
      case (state)
        S_IDLE: if (!q_empty) state <= S_LOAD;
        S_LOAD: begin
          addr_q <= first_addr;
          left_q <= q_cmd.words;
          wait_q <= q_cmd.src[0];
          wb_q   <= (q_cmd.dst != NO_DEST);
          if (q_cmd.words == '0) begin
            state <= S_FINISH;
          end else begin
            mem_rd_en   <= 1'b1;
            mem_rd_addr <= first_addr;
            state       <= S_READ;
          end
        end
        S_READ: begin
          mem_rd_en <= 1'b0;
          state     <= S_CAPT;
        end
        S_CAPT: begin
          str_data  <= mem_rd_data;
          str_wb    <= wb_q;
          str_valid <= 1'b1;
          state     <= S_SEND;
        end
        S_SEND: if (str_ready) begin
          str_valid <= 1'b0;
          if (left_q == LEN_W'(1)) begin
            state <= S_FINISH;
          end else begin
            left_q      <= left_q - 1'b1;
            addr_q      <= addr_q + ADDR_W'(4);
            mem_rd_en   <= 1'b1;
            mem_rd_addr <= addr_q + ADDR_W'(4);
            state       <= S_READ;
          end
        end
        S_FINISH: begin
          if (wait_q) begin
            state <= S_PWAIT;
          end else begin
            evt_done <= 1'b1;
            state    <= S_IDLE;
          end
        end
        S_PWAIT: if (port_idle) begin
          evt_done <= 1'b1;
          evt_port <= 1'b1;
          state    <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R4: a pending word is held until accepted; no read while one waits
  a_r4_hold_word: assert property (@(posedge clk) disable iff (rst)
    (str_valid && !str_ready) |=> (str_valid && $stable(str_data)));
  a_r4_no_read_pending: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> !str_valid);
  // R3: every read address is word aligned
  a_r3_aligned: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> (mem_rd_addr[1:0] == 2'b00));
  // R6: the port-done event always comes with the completion event
  a_r6_port_with_done: assert property (@(posedge clk) disable iff (rst)
    evt_port |-> evt_done);
  a_r6_port_needs_idle: assert property (@(posedge clk) disable iff (rst)
    evt_port |-> $past(port_idle));
endmodule

// File: rtl/cfg_dma_front.sv
module cfg_dma_front
  import dmafe_pkg::*;
#(
  parameter int CMDQ_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_we,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic        q_full,
  output logic        q_empty,
  output logic        evt_dma_done,
  output logic        evt_port_done,
  output logic        evt_q_overflow,
  output logic        mem_rd_en,
  output logic [31:0] mem_rd_addr,
  input  logic [31:0] mem_rd_data,
  output logic        cfg_valid,
  output logic [31:0] cfg_data,
  output logic        cfg_writeback,
  input  logic        cfg_ready,
  input  logic        cfg_port_idle
);
  localparam int CMD_W = $bits(dma_cmd_t);

  logic             push, pop;
  dma_cmd_t         staged, head;
  logic [CMD_W-1:0] head_vec;

  dmafe_stage u_stage (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .full(q_full), .push(push), .cmd(staged), .ovf(evt_q_overflow)
  );

  dmafe_cmdq #(.DEPTH(CMDQ_DEPTH), .WIDTH(CMD_W)) u_cmdq (
    .clk(clk), .rst(rst), .push(push), .wdata(staged), .pop(pop),
    .rdata(head_vec), .full(q_full), .empty(q_empty)
  );

  assign head = dma_cmd_t'(head_vec);

  dmafe_fetch u_fetch (
    .clk(clk), .rst(rst), .q_empty(q_empty), .q_cmd(head), .q_pop(pop),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .str_valid(cfg_valid), .str_data(cfg_data), .str_wb(cfg_writeback),
    .str_ready(cfg_ready), .port_idle(cfg_port_idle),
    .evt_done(evt_dma_done), .evt_port(evt_port_done)
  );

  // R8: status flags are mutually exclusive
  a_r8_flags_excl: assert property (@(posedge clk) disable iff (rst)
    !(q_full && q_empty));
endmodule

// File: tb/test_cfg_dma_front.sv
module test_cfg_dma_front;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        q_full, q_empty, evt_dma_done, evt_port_done, evt_q_overflow;
  logic        mem_rd_en;
  logic [31:0] mem_rd_addr, mem_rd_data;
  logic        cfg_valid, cfg_writeback;
  logic [31:0] cfg_data;
  logic        cfg_ready = 1'b1;
  logic        cfg_port_idle = 1'b1;

  int checks = 0, fails = 0;
  int n_done = 0, n_port = 0, n_ovf = 0, n_reads = 0;

  always #5 clk = ~clk;

  cfg_dma_front i_cfg_dma_front (.*);

  function automatic logic [31:0] word_at(input logic [31:0] a);
    return {a[15:0], ~a[15:0]};
  endfunction

  always_ff @(posedge clk) if (mem_rd_en) mem_rd_data <= word_at(mem_rd_addr);

  always @(posedge clk) if (!rst) begin
    if (evt_dma_done)   n_done++;
    if (evt_port_done)  n_port++;
    if (evt_q_overflow) n_ovf++;
    if (mem_rd_en)      n_reads++;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic issue(input logic [31:0] s, input logic [31:0] d, input logic [31:0] n);
    wr(8'h18, s); wr(8'h1C, d); wr(8'h20, n); wr(8'h24, 32'h0);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic take(input logic [31:0] a, input logic wb, input string req);
    int t = 0;
    while (!cfg_valid && t < 60) begin @(negedge clk); t++; end
    check(cfg_valid, req, {31'b0, cfg_valid}, 32'h1);
    check(cfg_data == word_at(a), req, cfg_data, word_at(a));
    check(cfg_writeback == wb, req, {31'b0, cfg_writeback}, {31'b0, wb});
    @(negedge clk);
  endtask

  task automatic t_reset;
    check(q_empty && !q_full, "R11", {30'b0, q_full, q_empty}, 32'h1);
    check(!cfg_valid && !mem_rd_en, "R11", {30'b0, cfg_valid, mem_rd_en}, 32'h0);
    check(n_done == 0 && n_ovf == 0 && n_port == 0, "R11", n_done, 0);
  endtask

  task automatic t_basic;
    int d0 = n_done, p0 = n_port, r0 = n_reads;
    wr(8'h40, 32'hDEAD_0000);
    issue(32'h0000_1002, 32'h0000_2000, 32'h3);
    take(32'h1000, 1'b1, "R1 R3");
    take(32'h1004, 1'b1, "R3");
    take(32'h1008, 1'b1, "R3");
    idle(6);
    check(n_reads - r0 == 3, "R2", n_reads - r0, 3);
    check(n_done - d0 == 1 && n_port == p0, "R6", n_done - d0, 1);
  endtask

  task automatic t_len_mask;
    int r0 = n_reads;
    issue(32'h0000_5000, 32'h0, 32'hF800_0002);
    take(32'h5000, 1'b1, "R2");
    take(32'h5004, 1'b1, "R2");
    idle(6);
    check(n_reads - r0 == 2, "R2", n_reads - r0, 2);
  endtask

  task automatic t_stall;
    logic [31:0] held;
    int r0;
    cfg_ready = 1'b0;
    issue(32'h0000_4000, 32'h0, 32'h2);
    idle(8);
    held = cfg_data;
    r0 = n_reads;
    idle(6);
    check(cfg_valid && cfg_data == held && held == word_at(32'h4000), "R4", cfg_data, word_at(32'h4000));
    check(n_reads == r0, "R4", n_reads, r0);
    cfg_ready = 1'b1;
    @(negedge clk);
    take(32'h4004, 1'b1, "R4");
    idle(4);
  endtask

  task automatic t_zero;
    int d0 = n_done, r0 = n_reads;
    issue(32'h0000_7000, 32'h0, 32'h0);
    idle(8);
    check(n_done - d0 == 1, "R5", n_done - d0, 1);
    check(n_reads == r0 && !cfg_valid, "R5", n_reads - r0, 0);
  endtask

  task automatic t_port_wait;
    int d0 = n_done, p0 = n_port;
    cfg_port_idle = 1'b0;
    issue(32'h0000_3001, 32'h0, 32'h1);
    take(32'h3000, 1'b1, "R6");
    idle(10);
    check(n_done == d0 && n_port == p0, "R6", n_done - d0, 0);
    cfg_port_idle = 1'b1;
    idle(4);
    check(n_done - d0 == 1 && n_port - p0 == 1, "R6", n_port - p0, 1);
  endtask

  task automatic t_nodst;
    issue(32'h0000_6000, 32'hFFFF_FFFF, 32'h1);
    take(32'h6000, 1'b0, "R7");
    idle(4);
  endtask

  task automatic t_queue;
    int o0 = n_ovf, r0 = n_reads;
    cfg_ready = 1'b0;
    issue(32'h100, 32'h0, 32'h1);
    idle(6);
    check(q_empty, "R8", {31'b0, q_empty}, 32'h1);
    for (int k = 2; k <= 5; k++) issue(32'(k * 256), 32'h0, 32'h1);
    check(q_full && !q_empty, "R8", {30'b0, q_full, q_empty}, 32'h2);
    issue(32'h600, 32'h0, 32'h1);
    idle(2);
    check(n_ovf - o0 == 1, "R9", n_ovf - o0, 1);
    wr(8'h18, 32'h900); wr(8'h1C, 32'hFFFF_FFFF); wr(8'h20, 32'h7);
    check(q_full, "R10", {31'b0, q_full}, 32'h1);
    cfg_ready = 1'b1;
    for (int k = 1; k <= 5; k++) take(32'(k * 256), 1'b1, "R8 R10");
    idle(10);
    check(!cfg_valid && q_empty, "R9", {31'b0, cfg_valid}, 32'h0);
    check(n_reads - r0 == 5, "R9", n_reads - r0, 5);
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_basic;
    t_len_mask;
    t_stall;
    t_zero;
    t_port_wait;
    t_nodst;
    t_queue;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule